// File: doc/BRIEF.md
# Sector Read Command Sequencer

This block sits on the host side of a byte-wide register bus that leads to a flash-card controller. A single start pulse, a 28-bit logical block address and an 8-bit sector count begin a multi-sector read. The block waits for the card side to report that it is ready, then programs the controller with a fixed, ordered series of register writes. It holds the configuration-port reset bit high while it drains the data buffer. Once every requested byte has been read, it releases the controller.

Each returned byte appears on a byte stream with a one-cycle valid flag. A busy flag covers the whole operation, and a done pulse marks its end. The block always reads the complete requested amount before the release write, because a short drain can leave the card side stuck.

Top module: `sector_read_seq`

## Requirements
- R1: After a start pulse the block makes no bus access, with both strobes low, until `card_ready` is sampled high. `busy` is high from the cycle after the start pulse.
- R2: The first four writes put the starting address on the bus. Bits 7:0 go to 0x10, bits 15:8 to 0x11, bits 23:16 to 0x12, and bits 27:24 to 0x13 with the upper nibble of that byte zero.
- R3: The fifth write puts the sector count at 0x14. The sixth puts the read command code 0x03 at 0x15.
- R4: The seventh write puts 0x82 at 0x18 (bit 7 reset on, bit 1 lock request held). It comes directly after the command write and before any buffer read.
- R5: The block issues exactly count × 512 read strobes, all to the buffer address `BUF_ADDR` (default 0x40). A count of 0 means 256 sectors.
- R6: The byte present on `bus_rdata` during a read strobe appears on `rd_byte` in the next cycle, with `rd_valid` high for that one cycle.
- R7: After the last read the block writes 0x00 to 0x18. In the cycle after that write, `busy` is low and `done` pulses for one cycle.
- R8: A start pulse that arrives while `busy` is high has no effect on the bus sequence.
- R9: A synchronous `rst` returns the block to idle, with `busy`, `done`, `rd_valid`, `bus_we` and `bus_re` all low.
- R10: Each strobe lasts one cycle per access, and `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a read |
| lba | input | 28 | Starting logical block address |
| sec_count | input | 8 | Sector count, 0 means 256 |
| card_ready | input | 1 | Card side can accept a new command |
| bus_addr | output | 8 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_rdata | input | 8 | Register bus read data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| rd_byte | output | 8 | Byte read from the data buffer |
| rd_valid | output | 1 | `rd_byte` is valid this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Patterns include the following:
- A delayed `card_ready` and an immediate one, which separates waiting from starting early.
- An address with every bit set, which shows whether the upper nibble of the top byte is masked.
- Counts of 1, 2 and 3 sectors, which expose off-by-one drain lengths.
- A count of 0, which exercises the 256-sector wrap.
- A start pulse during a drain and a reset in mid-drain, which show that the sequence ignores the first and recovers cleanly from the second.

The device model returns a distinct byte for each read, so a lost or duplicated byte shows up on the stream.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int DATA_W = 8;
  localparam logic [7:0] A_LBA0    = 8'h10;
  localparam logic [7:0] A_LBA1    = 8'h11;
  localparam logic [7:0] A_LBA2    = 8'h12;
  localparam logic [7:0] A_LBA3    = 8'h13;
  localparam logic [7:0] A_COUNT   = 8'h14;
  localparam logic [7:0] A_CMD     = 8'h15;
  localparam logic [7:0] A_CTRL    = 8'h18;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CTRL_HOLD = 8'h82;
  localparam logic [7:0] CTRL_FREE = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_WR, S_RD, S_REL, S_FIN
  } seq_state_t;
endpackage

// File: rtl/srs_cmd_table.sv
module srs_cmd_table #(
  parameter int ADDR_W = 8,
  parameter int LBA_W  = 28,
  parameter int SEC_W  = 8,
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic [LBA_W-1:0]  lba,
  input  logic [SEC_W-1:0]  count,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  import srs_pkg::*;
  localparam int EXT_W = 32;
  logic [EXT_W-1:0] lba_ext;

  assign lba_ext = EXT_W'(lba);

  always_comb begin
    case (step)
      STEP_W'(0): begin addr = ADDR_W'(A_LBA0);  data = lba_ext[7:0];   end
      STEP_W'(1): begin addr = ADDR_W'(A_LBA1);  data = lba_ext[15:8];  end
      STEP_W'(2): begin addr = ADDR_W'(A_LBA2);  data = lba_ext[23:16]; end
      STEP_W'(3): begin addr = ADDR_W'(A_LBA3);  data = {4'h0, lba_ext[27:24]}; end
      STEP_W'(4): begin addr = ADDR_W'(A_COUNT); data = 8'(count);      end
      STEP_W'(5): begin addr = ADDR_W'(A_CMD);   data = CMD_READ;       end
      default:    begin addr = ADDR_W'(A_CTRL);  data = CTRL_HOLD;      end
    endcase
  end
endmodule

// File: rtl/srs_byte_counter.sv
module srs_byte_counter #(
  parameter int SEC_W        = 8,
  parameter int SECTOR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEC_W-1:0] count,
  input  logic             dec,
  output logic             last
);
  localparam int TOTAL_W = $clog2((1 << SEC_W) * SECTOR_BYTES) + 1;
  logic [TOTAL_W-1:0] remain;
  logic [TOTAL_W-1:0] sectors;

  assign sectors = (count == '0) ? (TOTAL_W'(1) << SEC_W) : TOTAL_W'(count);
  assign last    = (remain == TOTAL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= sectors * TOTAL_W'(SECTOR_BYTES);
    end else if (dec) begin
      remain <= remain - TOTAL_W'(1);
    end
  end

  // R5: a read is never issued with nothing left to read
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remain != '0));
endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq #(
  parameter int ADDR_W       = 8,
  parameter int LBA_W        = 28,
  parameter int SEC_W        = 8,
  parameter int SECTOR_BYTES = 512,
  parameter logic [ADDR_W-1:0] BUF_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LBA_W-1:0]  lba,
  input  logic [SEC_W-1:0]  sec_count,
  input  logic              card_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic [7:0]        rd_byte,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);
  import srs_pkg::*;
  localparam int STEP_W    = 3;
  localparam int LAST_STEP = 6;

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [LBA_W-1:0]  lba_q;
  logic [SEC_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] tbl_addr;
  logic [7:0]        tbl_data;
  logic              cnt_load;
  logic              cnt_dec;
  logic              cnt_last;

  srs_cmd_table #(
    .ADDR_W(ADDR_W), .LBA_W(LBA_W), .SEC_W(SEC_W), .STEP_W(STEP_W)
  ) u_table (
    .step(step), .lba(lba_q), .count(cnt_q), .addr(tbl_addr), .data(tbl_data)
  );

  assign cnt_load = (state == S_WAIT) && card_ready;
  assign cnt_dec  = (state == S_RD);

  srs_byte_counter #(
    .SEC_W(SEC_W), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_count (
    .clk(clk), .rst(rst), .load(cnt_load), .count(cnt_q),
    .dec(cnt_dec), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      lba_q     <= '0;
      cnt_q     <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      rd_byte   <= '0;
      rd_valid  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      bus_we   <= 1'b0;
      bus_re   <= 1'b0;
      done     <= 1'b0;
      rd_valid <= bus_re;
      if (bus_re) rd_byte <= bus_rdata;
      case (state)
        S_IDLE: if (start) begin
          lba_q <= lba;
          cnt_q <= sec_count;
          busy  <= 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: if (card_ready) begin
          step  <= '0;
          state <= S_WR;
        end
        S_WR: begin
          bus_we    <= 1'b1;
          bus_addr  <= tbl_addr;
          bus_wdata <= tbl_data;
          step      <= step + STEP_W'(1);
          if (step == STEP_W'(LAST_STEP)) state <= S_RD;
        end
        S_RD: begin
          bus_re   <= 1'b1;
          bus_addr <= BUF_ADDR;
          if (cnt_last) state <= S_REL;
        end
        S_REL: begin
          bus_we    <= 1'b1;
          bus_addr  <= ADDR_W'(A_CTRL);
          bus_wdata <= CTRL_FREE;
          state     <= S_FIN;
        end
        S_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_we && !bus_re));
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  p_read_addr_r5: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> (bus_addr == BUF_ADDR));
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> rd_valid);
  p_done_end_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(bus_we)));
  p_hold_before_read_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_re)) |-> ($past(bus_we) && $past(bus_wdata) == CTRL_HOLD));
endmodule

// File: tb/sector_read_seq_tb.sv
module sector_read_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [27:0] lba = '0;
  logic [7:0]  sec_count = '0;
  logic        card_ready = 1'b0;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata, rd_byte;
  logic        bus_we, bus_re, rd_valid, busy, done;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  int dev_idx = 0;
  int rd_cnt = 0;

  always #2.5 clk = ~clk;

  sector_read_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .lba(lba), .sec_count(sec_count),
    .card_ready(card_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_re(bus_re),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .busy(busy), .done(done)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  assign bus_rdata = pat(dev_idx);
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst && bus_re) dev_idx <= dev_idx + 1;
  end

  typedef struct {
    bit we; bit re; bit [7:0] addr; bit [7:0] wdata; bit busy; bit done; string tag;
  } ev_t;

  ev_t q[$];
  ev_t exp_e, prev_e;
  bit  m_busy = 0, m_wait = 0, exp_rv = 0;
  bit [7:0] exp_rb = 0;
  bit [27:0] m_lba;
  bit [7:0]  m_cnt;
  int ridx = 0;

  function automatic ev_t mk(bit we, bit re, bit [7:0] a, bit [7:0] d, bit b, bit dn, string t);
    ev_t e;
    e.we = we; e.re = re; e.addr = a; e.wdata = d; e.busy = b; e.done = dn; e.tag = t;
    return e;
  endfunction

  // Behavioural reference: expected outputs after each rising edge
  always @(posedge clk) begin
    bit pre_busy;
    if (rst) begin
      q.delete();
      m_busy = 0; m_wait = 0; exp_rv = 0; exp_rb = 0;
      exp_e = mk(0, 0, 0, 0, 0, 0, "R9");
      prev_e = exp_e;
    end else begin
      pre_busy = m_busy;
      exp_rv = prev_e.re;
      if (prev_e.re) begin exp_rb = pat(ridx); ridx++; end
      if (q.size() > 0) begin
        exp_e = q.pop_front();
        if (exp_e.done) m_busy = 0;
      end else if (m_wait && card_ready) begin
        int n;
        n = (m_cnt == 0) ? 256 * 512 : m_cnt * 512;
        q.push_back(mk(1, 0, 8'h10, m_lba[7:0], 1, 0, "R2"));
        q.push_back(mk(1, 0, 8'h11, m_lba[15:8], 1, 0, "R2"));
        q.push_back(mk(1, 0, 8'h12, m_lba[23:16], 1, 0, "R2"));
        q.push_back(mk(1, 0, 8'h13, {4'h0, m_lba[27:24]}, 1, 0, "R2"));
        q.push_back(mk(1, 0, 8'h14, m_cnt, 1, 0, "R3"));
        q.push_back(mk(1, 0, 8'h15, 8'h03, 1, 0, "R3"));
        q.push_back(mk(1, 0, 8'h18, 8'h82, 1, 0, "R4"));
        for (int i = 0; i < n; i++) q.push_back(mk(0, 1, 8'h40, 8'h00, 1, 0, "R5"));
        q.push_back(mk(1, 0, 8'h18, 8'h00, 1, 0, "R7"));
        q.push_back(mk(0, 0, 8'h00, 8'h00, 0, 1, "R7"));
        m_wait = 0;
        exp_e = mk(0, 0, 0, 0, 1, 0, "R1");
      end else begin
        exp_e = mk(0, 0, 0, 0, m_busy, 0, m_busy ? "R1" : "R8");
      end
      if (!pre_busy && start) begin
        m_busy = 1; m_wait = 1; m_lba = lba; m_cnt = sec_count;
        exp_e.busy = 1;
      end
      prev_e = exp_e;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (cycles > 1) begin
      bit mism;
      mism = (bus_we !== exp_e.we) || (bus_re !== exp_e.re) ||
             (busy !== exp_e.busy) || (done !== exp_e.done);
      if (exp_e.we || exp_e.re) mism = mism || (bus_addr !== exp_e.addr);
      if (exp_e.we) mism = mism || (bus_wdata !== exp_e.wdata);
      checks++;
      if (mism) begin
        bad++;
        $display("FAIL %s: we=%b re=%b addr=%h wd=%h busy=%b done=%b exp we=%b re=%b addr=%h wd=%h busy=%b done=%b",
                 exp_e.tag, bus_we, bus_re, bus_addr, bus_wdata, busy, done,
                 exp_e.we, exp_e.re, exp_e.addr, exp_e.wdata, exp_e.busy, exp_e.done);
      end
      checks++;
      if ((rd_valid !== exp_rv) || (exp_rv && rd_byte !== exp_rb)) begin
        bad++;
        $display("FAIL R6: rd_valid=%b rd_byte=%h exp %b %h", rd_valid, rd_byte, exp_rv, exp_rb);
      end
      if (rd_valid) rd_cnt++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run_txn(bit [27:0] a, bit [7:0] c, int ready_delay, bit poke);
    int n;
    n = (c == 0) ? 256 * 512 : c * 512;
    @(negedge clk);
    card_ready = 0;
    lba = a; sec_count = c; start = 1; rd_cnt = 0;
    @(negedge clk);
    start = 0;
    repeat (ready_delay) @(negedge clk);
    card_ready = 1;
    if (poke) begin
      // R8: second request in mid-drain
      repeat (40) @(negedge clk);
      lba = 28'h1234567; sec_count = 8'd9; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done && cycles < 190000) @(negedge clk);
    chk(rd_cnt == n, "R5 read count", rd_cnt, n);
    chk(busy == 0, "R7 busy after done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R7 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_we && !bus_re && !busy && !done && !rd_valid, "R9 reset state", busy, 0);
    rst = 0;
    run_txn(28'hA5B6C7D, 8'd1, 6, 0);
    run_txn(28'h0000001, 8'd3, 0, 1);
    run_txn(28'hFFFFFFF, 8'd2, 1, 0);
    // R9: reset during the drain
    @(negedge clk);
    lba = 28'h0ABCDEF; sec_count = 8'd2; start = 1;
    @(negedge clk);
    start = 0; card_ready = 1;
    repeat (300) @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!bus_we && !bus_re && !busy && !done, "R9 mid-drain reset", busy, 0);
    rst = 0;
    run_txn(28'h7654321, 8'd1, 2, 0);
    run_txn(28'h0102030, 8'd0, 3, 0);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    while (cycles < 195000) @(negedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 195000);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule